// File: doc/BRIEF.md
# Interruptible Segment Erase Scheduler

This block decides how pending interrupts meet a segment erase that is running on the flash timing clock. It starts the erase, gives the timing engine a run enable, and chooses one of three policies from two mode bits. With both bits clear, interrupts are held off until the erase ends. In abort mode, a pending interrupt ends the erase at once and raises a sticky failure flag. In sliced mode, the erase is cut into slices of a fixed number of timing-clock cycles. An interrupt can be granted only at the end of a slice. While it is serviced, the erase is paused.

During a pause the block stays busy, but it signals that CPU flash accesses are allowed. Servicing ends when the return-from-interrupt strobe arrives. The erase then resumes with a fresh slice, so another full slice always runs before the next grant. Only one level of interrupt is tracked.

Top module: `erase_slicer`

## Requirements
- R1: After reset, busy, eraseRun, accessOk and failFlag are 0. While idle, irqGrant equals gie AND irqPending.
- R2: An eraseStart pulse while idle makes busy and eraseRun 1 after the next clock edge. An eraseStart while busy has no effect and does not restart the slice count.
- R3: With sliceEn=0 and abortEn=0, irqGrant stays 0 for the whole erase. After eraseDone the block is idle, and a request that is still pending is then granted.
- R4: With abortEn=1 and gie=1, a pending interrupt during a running erase makes busy and eraseRun 0 and failFlag 1 after the next edge. This applies whatever the value of sliceEn.
- R5: With sliceEn=1, abortEn=0, gie=1 and irqPending=1, the erase pauses after exactly SLICE_LEN run cycles counted from the start. While paused, eraseRun=0 and irqGrant=1.
- R6: While paused, busy=1 and accessOk=1. accessOk is 0 at all other times.
- R7: A pause lasts until retiSeen is 1. The next edge restarts the erase with a zeroed slice count, so at least SLICE_LEN further run cycles pass before the next pause.
- R8: With gie=0, the erase neither pauses nor aborts, whatever irqPending is.
- R9: eraseDone during a run returns the block to idle on the next edge. When eraseDone and an abort condition arrive together, eraseDone wins and failFlag is not set.
- R10: failFlag stays set until failClr is 1. If a failure sets the flag in the same cycle as failClr, the flag stays set.
- R11: A reset during an erase ends it at once: busy and eraseRun go to 0.
- R12: The slice count wraps every SLICE_LEN run cycles. A request that arrives in the middle of a slice is granted only at the next slice boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flash timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eraseStart | input | 1 | Pulse that starts a segment erase |
| eraseDone | input | 1 | Completion strobe from the timing engine |
| gie | input | 1 | Global interrupt enable |
| irqPending | input | 1 | An interrupt is pending |
| retiSeen | input | 1 | Return-from-interrupt detected |
| sliceEn | input | 1 | Mode bit: interruptible erase |
| abortEn | input | 1 | Mode bit: abort on interrupt |
| failClr | input | 1 | Clears the failure flag |
| eraseRun | output | 1 | Run enable to the timing engine |
| irqGrant | output | 1 | Interrupt may be taken |
| accessOk | output | 1 | Flash access allowed while busy |
| failFlag | output | 1 | Sticky erase failure |
| busy | output | 1 | Erase in progress, including pauses |

## Verification
The bench builds the block with the default SLICE_LEN of 32. This puts the exact slice boundary within reach, both the first one after a start and the one after a resume. It also reaches the wrap to a second boundary at run cycle 64, which is how a restart caused by a stray start pulse would show. These tests stay short because the count is small. Exact timing is checked at the cycle before and the cycle of each boundary.

// File: rtl/erase_slicer_pkg.sv
package erase_slicer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } phase_t;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic failSet;
  } ctrl_strobe_t;

endpackage

// File: rtl/erase_slicer_dp.sv
module erase_slicer_dp
  import erase_slicer_pkg::*;
#(
  parameter int SLICE_LEN = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctrl_strobe_t strobes,
  input  logic         failClr,
  output logic         sliceEnd,
  output logic         failFlag
);
  localparam int CNT_W = (SLICE_LEN > 2) ? $clog2(SLICE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLICE_LEN - 1);

  logic [CNT_W-1:0] sliceCnt;

  // slice counter: advances only while the erase runs, wraps per slice
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sliceCnt <= '0;
    end else if (strobes.cntClear) begin
      sliceCnt <= '0;
    end else if (strobes.cntStep) begin
      sliceCnt <= (sliceCnt == LAST) ? '0 : sliceCnt + 1'b1;
    end
  end

  assign sliceEnd = (sliceCnt == LAST);

  // sticky failure flag, set beats clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failFlag <= 1'b0;
    end else if (strobes.failSet) begin
      failFlag <= 1'b1;
    end else if (failClr) begin
      failFlag <= 1'b0;
    end
  end

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.cntClear |=> (sliceCnt == '0));

  a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (failFlag && !failClr) |=> failFlag);

  a_r4_fail_set: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.failSet |=> failFlag);

endmodule

// File: rtl/erase_slicer_ctrl.sv
module erase_slicer_ctrl
  import erase_slicer_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eraseStart,
  input  logic         eraseDone,
  input  logic         gie,
  input  logic         irqPending,
  input  logic         retiSeen,
  input  logic         sliceEn,
  input  logic         abortEn,
  input  logic         sliceEnd,
  output ctrl_strobe_t strobes,
  output logic         eraseRun,
  output logic         irqGrant,
  output logic         accessOk,
  output logic         busy
);
  phase_t phase, phaseNxt;
  logic   abortHit, sliceHit;

  assign abortHit = abortEn && gie && irqPending;
  assign sliceHit = sliceEn && !abortEn && gie && irqPending && sliceEnd;

  always_comb begin
    phaseNxt = phase;
    strobes  = '0;
    unique case (phase)
      ST_IDLE: begin
        if (eraseStart) begin
          phaseNxt         = ST_RUN;
          strobes.cntClear = 1'b1;
        end
      end
      ST_RUN: begin
        strobes.cntStep = 1'b1;
        if (eraseDone) begin
          phaseNxt = ST_IDLE;
        end else if (abortHit) begin
          phaseNxt        = ST_IDLE;
          strobes.failSet = 1'b1;
        end else if (sliceHit) begin
          phaseNxt = ST_PAUSE;
        end
      end
      ST_PAUSE: begin
        if (retiSeen) begin
          phaseNxt         = ST_RUN;
          strobes.cntClear = 1'b1;
        end
      end
      default: phaseNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= ST_IDLE;
    else        phase <= phaseNxt;
  end

  assign busy     = (phase != ST_IDLE);
  assign eraseRun = (phase == ST_RUN);
  assign accessOk = (phase == ST_PAUSE);
  assign irqGrant = (phase == ST_PAUSE) || ((phase == ST_IDLE) && gie && irqPending);

  a_r5_pause_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_RUN && phaseNxt == ST_PAUSE) |-> sliceEnd);

  a_r6_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accessOk |-> busy);

  a_r7_hold_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_PAUSE && !retiSeen) |=> (phase == ST_PAUSE));

  a_r8_no_gie_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_RUN && !gie && !eraseDone) |=> (phase == ST_RUN));

  a_r9_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_RUN && eraseDone) |-> !strobes.failSet);

endmodule

// File: rtl/erase_slicer.sv
module erase_slicer
  import erase_slicer_pkg::*;
#(
  parameter int SLICE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eraseStart,
  input  logic eraseDone,
  input  logic gie,
  input  logic irqPending,
  input  logic retiSeen,
  input  logic sliceEn,
  input  logic abortEn,
  input  logic failClr,
  output logic eraseRun,
  output logic irqGrant,
  output logic accessOk,
  output logic failFlag,
  output logic busy
);
  ctrl_strobe_t strobes;
  logic         sliceEnd;

  erase_slicer_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .eraseStart (eraseStart),
    .eraseDone  (eraseDone),
    .gie        (gie),
    .irqPending (irqPending),
    .retiSeen   (retiSeen),
    .sliceEn    (sliceEn),
    .abortEn    (abortEn),
    .sliceEnd   (sliceEnd),
    .strobes    (strobes),
    .eraseRun   (eraseRun),
    .irqGrant   (irqGrant),
    .accessOk   (accessOk),
    .busy       (busy)
  );

  erase_slicer_dp #(.SLICE_LEN(SLICE_LEN)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .failClr  (failClr),
    .sliceEnd (sliceEnd),
    .failFlag (failFlag)
  );

  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    eraseRun |-> busy);

endmodule

// File: tb/sim_erase_slicer.sv
module sim_erase_slicer;
  localparam int CLK_PERIOD = 10;
  localparam int SLICE = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eraseStart = 0, eraseDone = 0, gie = 0, irqPending = 0, retiSeen = 0;
  logic sliceEn = 0, abortEn = 0, failClr = 0;
  logic eraseRun, irqGrant, accessOk, failFlag, busy;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_slicer #(.SLICE_LEN(SLICE)) u0 (
    .clk(clk), .rst_n(rst_n), .eraseStart(eraseStart), .eraseDone(eraseDone),
    .gie(gie), .irqPending(irqPending), .retiSeen(retiSeen), .sliceEn(sliceEn),
    .abortEn(abortEn), .failClr(failClr), .eraseRun(eraseRun), .irqGrant(irqGrant),
    .accessOk(accessOk), .failFlag(failFlag), .busy(busy)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 0;
    {eraseStart, eraseDone, gie, irqPending, retiSeen, sliceEn, abortEn, failClr} = '0;
    waitN(2);
    rst_n = 1;
    waitN(1);
  endtask

  // start pulse; returns at the negedge after the start edge
  task automatic startErase();
    eraseStart = 1;
    waitN(1);
    eraseStart = 0;
  endtask

  task automatic finishErase();
    eraseDone = 1;
    waitN(1);
    eraseDone = 0;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 busy", busy, 0);
    chk("R1 run", eraseRun, 0);
    chk("R1 access", accessOk, 0);
    chk("R1 fail", failFlag, 0);
    gie = 1; irqPending = 1; #1;
    chk("R1 idle grant", irqGrant, 1);
    gie = 0; #1;
    chk("R1 idle grant gie0", irqGrant, 0);
    irqPending = 0;
  endtask

  task automatic testHeldOff();
    logic sawGrant;
    doReset();
    gie = 1; irqPending = 1;
    startErase();
    chk("R2 busy", busy, 1);
    chk("R2 run", eraseRun, 1);
    sawGrant = 0;
    for (int i = 0; i < 70; i++) begin
      if (irqGrant) sawGrant = 1;
      waitN(1);
    end
    chk("R3 no grant during erase", sawGrant, 0);
    chk("R3 still running", eraseRun, 1);
    finishErase();
    chk("R9 idle after done", busy, 0);
    chk("R3 grant after done", irqGrant, 1);
    chk("R9 no fail", failFlag, 0);
  endtask

  task automatic testAbort();
    doReset();
    gie = 1; abortEn = 1; sliceEn = 1;
    startErase();
    waitN(10);
    irqPending = 1;
    failClr = 1;
    waitN(1);
    failClr = 0;
    chk("R4 busy off", busy, 0);
    chk("R4 run off", eraseRun, 0);
    chk("R10 set beats clear", failFlag, 1);
    irqPending = 0;
    waitN(5);
    chk("R10 sticky", failFlag, 1);
    failClr = 1;
    waitN(1);
    failClr = 0;
    chk("R10 cleared", failFlag, 0);
  endtask

  task automatic testSliceResume();
    doReset();
    gie = 1; sliceEn = 1; irqPending = 1;
    startErase();
    waitN(SLICE - 1);
    chk("R5 run before boundary", eraseRun, 1);
    waitN(1);
    chk("R5 paused at boundary", eraseRun, 0);
    chk("R5 grant", irqGrant, 1);
    chk("R6 busy in pause", busy, 1);
    chk("R6 access in pause", accessOk, 1);
    waitN(8);
    chk("R7 holds pause", accessOk, 1);
    retiSeen = 1;
    waitN(1);
    retiSeen = 0;
    chk("R7 resumed", eraseRun, 1);
    chk("R6 access off", accessOk, 0);
    waitN(SLICE - 1);
    chk("R7 full slice after resume", eraseRun, 1);
    waitN(1);
    chk("R7 paused again", accessOk, 1);
    retiSeen = 1; irqPending = 0;
    waitN(1);
    retiSeen = 0;
    finishErase();
    chk("R9 done after resume", busy, 0);
  endtask

  task automatic testWrap();
    doReset();
    gie = 1; sliceEn = 1;
    startErase();
    waitN(19);
    eraseStart = 1;  // ignored while busy
    waitN(1);
    eraseStart = 0;
    waitN(19);
    irqPending = 1;
    waitN(2 * SLICE - 40);
    chk("R12 no grant mid slice", eraseRun, 1);
    chk("R2 start ignored", busy, 1);
    waitN(1);
    chk("R12 pause at next boundary", accessOk, 1);
    irqPending = 0;
  endtask

  task automatic testNoGie();
    doReset();
    gie = 0; irqPending = 1; abortEn = 1; sliceEn = 1;
    startErase();
    waitN(2 * SLICE + 5);
    chk("R8 still running", eraseRun, 1);
    chk("R8 no fail", failFlag, 0);
    abortEn = 0;
    waitN(SLICE);
    chk("R8 no pause", eraseRun, 1);
    gie = 1; abortEn = 1;
    eraseDone = 1;
    waitN(1);
    eraseDone = 0;
    chk("R9 done beats abort", failFlag, 0);
    chk("R9 idle", busy, 0);
  endtask

  task automatic testResetMid();
    doReset();
    startErase();
    waitN(7);
    rst_n = 0;
    #1;
    chk("R11 busy off", busy, 0);
    chk("R11 run off", eraseRun, 0);
    waitN(1);
    rst_n = 1;
    waitN(1);
  endtask

  initial begin
    testReset();
    testHeldOff();
    testAbort();
    testSliceResume();
    testWrap();
    testNoGie();
    testResetMid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end
endmodule